// File: doc/BRIEF.md
# Receive Word Half-Slip Realigner

This block sits behind a four-byte-wide 8b/10b receive path. It re-frames every 32-bit receive word so that a comma character always lands in the most significant byte lane. If the deserializer reports the comma in the top lane, the stream is already framed and each word passes straight through. If the comma shows up in byte lane [15:8], the stream has slipped by half a word. Each output word is then built from the low half of the previous input word and the high half of the current one. The per-byte status vectors travel through the same splice, so every flag stays attached to its byte: not-in-table, disparity error, K-character, comma and running disparity.

The shift decision is held in a mode register and changes only when a comma is seen. The output path is registered once in both modes, so a mode change never alters the latency. The clock-correction count describes a whole input word, so it cannot be split; it is delayed by the same register and is not realigned. A comma in either of the other two lanes cannot be fixed by a half-word splice. The block flags it as an error and keeps its current mode.

Top module: `rx_word_realigner`

## Requirements
- R1: Every output is registered once: the word on the outputs is due one clock after the input word it is formed from, in both modes.
- R2: A comma vector of exactly 1000 (bit 3 is the byte in data bits 31:24) selects pass mode. The output data then equals the input data of the previous cycle, unchanged.
- R3: A comma vector of exactly 0010 (bit 1 is the byte in data bits 15:8) selects swap mode. The output data is then {low 16 bits of the older input, high 16 bits of the newer input}. With inputs xxxxBC95 then B5B5FDB5, the output is BC95B5B5.
- R4: The five 4-bit status vectors (not-in-table, disparity error, K-character, comma, running disparity) get the same treatment as the data. In swap mode each output vector is {older input bits 1:0, newer input bits 3:2}; in pass mode it is copied.
- R5: A word whose comma vector is 0000 keeps the mode last chosen.
- R6: The 3-bit clock-correction count is copied to the output with one cycle of delay and is never spliced.
- R7: Any other non-zero comma vector (for example 0100 or 0001) raises align_err for that word's output cycle and leaves the mode unchanged.
- R8: out_valid is low after reset until a comma has been seen.
  - A 1000 comma makes the output formed from that same word valid.
  - A 0010 comma that moves the block out of pass mode, or arrives before any lock, makes that word's output invalid; the outputs after it are valid.
  - A 0010 comma that arrives while the block is already in swap mode keeps the output valid.
- R9: A synchronous reset clears all outputs to zero, puts the block in pass mode, unlocked, and clears the stored half word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 32 | Received word, byte 3 in bits 31:24 |
| in_nit | input | 4 | Per-byte not-in-table flags |
| in_derr | input | 4 | Per-byte disparity error flags |
| in_isk | input | 4 | Per-byte K-character flags |
| in_comma | input | 4 | Per-byte comma flags |
| in_rdisp | input | 4 | Per-byte running disparity |
| in_ccnt | input | 3 | Clock-correction count (whole word) |
| out_data | output | 32 | Realigned word |
| out_nit | output | 4 | Realigned not-in-table flags |
| out_derr | output | 4 | Realigned disparity error flags |
| out_isk | output | 4 | Realigned K-character flags |
| out_comma | output | 4 | Realigned comma flags |
| out_rdisp | output | 4 | Realigned running disparity |
| out_ccnt | output | 3 | Delayed clock-correction count |
| out_valid | output | 1 | Output word is correctly framed |
| align_err | output | 1 | Comma seen in an unsupported lane |

## Verification
Every result is due exactly one rising edge after the input word that completes it. A swap-mode word also carries the half word captured one edge earlier. The driver applies each word on a falling edge and pushes the expected result, which it computes from the requirements, into a queue. The monitor pops that entry 1 ns after the next rising edge, so each comparison falls in the cycle its result is due. The reset checks sample on the falling edge that follows the reset edge.

// File: rtl/rxwa_pkg.sv
`timescale 1ns/1ps
package rxwa_pkg;
    localparam int LANES      = 4;
    localparam int BYTE_W     = 8;
    localparam int DATA_W     = LANES * BYTE_W;
    localparam int HALF_LANES = LANES / 2;
    localparam int HALF_W     = DATA_W / 2;
    localparam int N_STAT     = 5;
    localparam int CCNT_W     = 3;

    // Supported comma positions: top lane, and top lane of the low half.
    localparam logic [LANES-1:0] COMMA_TOP = LANES'(1) << (LANES - 1);
    localparam logic [LANES-1:0] COMMA_MID = LANES'(1) << (HALF_LANES - 1);

    // Status vector slots in the packed status array.
    localparam int ST_NIT   = 0;
    localparam int ST_DERR  = 1;
    localparam int ST_ISK   = 2;
    localparam int ST_COMMA = 3;
    localparam int ST_RDISP = 4;

    typedef enum logic {
        MODE_PASS = 1'b0,
        MODE_SWAP = 1'b1
    } mode_e;

    typedef logic [N_STAT-1:0][LANES-1:0] stat_arr_t;
endpackage

// File: rtl/rxwa_half_splice.sv
`timescale 1ns/1ps
module rxwa_half_splice #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur_i,
    input  logic         swap_i,
    output logic [W-1:0] word_o
);
    localparam int H = W / 2;

    typedef struct packed {
        logic [H-1:0] low;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d.low = cur_i[H-1:0];
        if (swap_i) begin
            word_o = {hold_q.low, cur_i[W-1:H]};
        end else begin
            word_o = cur_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end
endmodule

// File: rtl/rxwa_mode_ctrl.sv
`timescale 1ns/1ps
module rxwa_mode_ctrl
    import rxwa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] comma_i,
    output logic             swap_o,
    output logic             valid_o,
    output logic             err_o
);
    typedef struct packed {
        mode_e mode;
        logic  locked;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic bad_lane;

    always_comb begin
        ctl_d    = ctl_q;
        swap_o   = (ctl_q.mode == MODE_SWAP);
        valid_o  = ctl_q.locked;
        bad_lane = 1'b0;
        if (comma_i == COMMA_TOP) begin
            ctl_d.mode   = MODE_PASS;
            ctl_d.locked = 1'b1;
            swap_o       = 1'b0;
            valid_o      = 1'b1;
        end else if (comma_i == COMMA_MID) begin
            ctl_d.mode   = MODE_SWAP;
            ctl_d.locked = 1'b1;
            swap_o       = 1'b1;
            valid_o      = ctl_q.locked && (ctl_q.mode == MODE_SWAP);
        end else if (comma_i != '0) begin
            bad_lane = 1'b1;
        end
        err_o = bad_lane;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{mode: MODE_PASS, locked: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_MODE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (comma_i == '0) |=> $stable(ctl_q.mode)); // R5
    AST_BAD_LANE_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (comma_i != '0 && comma_i != COMMA_TOP && comma_i != COMMA_MID)
        |=> ctl_q.mode == $past(ctl_q.mode)); // R7
    AST_NO_VALID_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.locked && comma_i != COMMA_TOP) |-> !valid_o); // R8
endmodule

// File: rtl/rx_word_realigner.sv
`timescale 1ns/1ps
module rx_word_realigner
    import rxwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_nit,
    input  logic [LANES-1:0]  in_derr,
    input  logic [LANES-1:0]  in_isk,
    input  logic [LANES-1:0]  in_comma,
    input  logic [LANES-1:0]  in_rdisp,
    input  logic [CCNT_W-1:0] in_ccnt,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_nit,
    output logic [LANES-1:0]  out_derr,
    output logic [LANES-1:0]  out_isk,
    output logic [LANES-1:0]  out_comma,
    output logic [LANES-1:0]  out_rdisp,
    output logic [CCNT_W-1:0] out_ccnt,
    output logic              out_valid,
    output logic              align_err
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        stat_arr_t         stat;
        logic [CCNT_W-1:0] ccnt;
        logic              valid;
        logic              err;
    } out_t;

    out_t              out_d, out_q;
    stat_arr_t         stat_in, stat_spl;
    logic [DATA_W-1:0] data_spl;
    logic              swap, word_ok, bad_lane;

    always_comb begin
        stat_in[ST_NIT]   = in_nit;
        stat_in[ST_DERR]  = in_derr;
        stat_in[ST_ISK]   = in_isk;
        stat_in[ST_COMMA] = in_comma;
        stat_in[ST_RDISP] = in_rdisp;
    end

    rxwa_mode_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .comma_i (in_comma),
        .swap_o  (swap),
        .valid_o (word_ok),
        .err_o   (bad_lane)
    );

    rxwa_half_splice #(.W(DATA_W)) u_data_splice (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (in_data),
        .swap_i (swap),
        .word_o (data_spl)
    );

    for (genvar g = 0; g < N_STAT; g++) begin : g_stat
        rxwa_half_splice #(.W(LANES)) u_stat_splice (
            .clk    (clk),
            .rst    (rst),
            .cur_i  (stat_in[g]),
            .swap_i (swap),
            .word_o (stat_spl[g])
        );
    end

    always_comb begin
        out_d.data  = data_spl;
        out_d.stat  = stat_spl;
        out_d.ccnt  = in_ccnt;
        out_d.valid = word_ok;
        out_d.err   = bad_lane;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_data  = out_q.data;
    assign out_nit   = out_q.stat[ST_NIT];
    assign out_derr  = out_q.stat[ST_DERR];
    assign out_isk   = out_q.stat[ST_ISK];
    assign out_comma = out_q.stat[ST_COMMA];
    assign out_rdisp = out_q.stat[ST_RDISP];
    assign out_ccnt  = out_q.ccnt;
    assign out_valid = out_q.valid;
    assign align_err = out_q.err;

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (in_comma == COMMA_TOP) |=> (out_data == $past(in_data)) && out_valid); // R2
    AST_SWAP_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
        (in_comma == COMMA_MID) |=> out_data[HALF_W-1:0] == $past(in_data[DATA_W-1:HALF_W])); // R3
    AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (in_comma == COMMA_TOP) |=> (out_isk == $past(in_isk)) && (out_rdisp == $past(in_rdisp))
                                    && (out_comma == COMMA_TOP)); // R4
    AST_CCNT_COPY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_ccnt == $past(in_ccnt)); // R6
    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_comma != '0 && in_comma != COMMA_TOP && in_comma != COMMA_MID) |=> align_err); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !out_valid && !align_err && out_data == '0 && out_ccnt == '0); // R9
endmodule

// File: tb/rx_word_realigner_bench.sv
`timescale 1ns/1ps
module rx_word_realigner_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_data = '0;
    logic [3:0]  in_nit = '0, in_derr = '0, in_isk = '0, in_comma = '0, in_rdisp = '0;
    logic [2:0]  in_ccnt = '0;
    logic [31:0] out_data;
    logic [3:0]  out_nit, out_derr, out_isk, out_comma, out_rdisp;
    logic [2:0]  out_ccnt;
    logic        out_valid, align_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] d;
        logic [3:0]  nit, derr, isk, cm, rd;
        logic [2:0]  cc;
        logic        v, e;
        string       req;
    } exp_t;

    exp_t sb[$];

    // Reference state kept from the requirements.
    bit         m_swap = 1'b0;
    bit         m_lock = 1'b0;
    logic [15:0] m_pd = '0;
    logic [1:0] m_pn = '0, m_pe = '0, m_pk = '0, m_pc = '0, m_pr = '0;

    always #2 clk = ~clk;

    rx_word_realigner u_rx_word_realigner (
        .clk(clk), .rst(rst),
        .in_data(in_data), .in_nit(in_nit), .in_derr(in_derr), .in_isk(in_isk),
        .in_comma(in_comma), .in_rdisp(in_rdisp), .in_ccnt(in_ccnt),
        .out_data(out_data), .out_nit(out_nit), .out_derr(out_derr), .out_isk(out_isk),
        .out_comma(out_comma), .out_rdisp(out_rdisp), .out_ccnt(out_ccnt),
        .out_valid(out_valid), .align_err(align_err)
    );

    function automatic logic [3:0] spl4(input bit sw, input logic [1:0] old, input logic [3:0] cur);
        return sw ? {old, cur[3:2]} : cur;
    endfunction

    task automatic drive(input logic [31:0] d, input logic [3:0] nit, input logic [3:0] derr,
                         input logic [3:0] isk, input logic [3:0] cm, input logic [3:0] rd,
                         input logic [2:0] cc, input string req);
        exp_t e;
        bit   sw;
        @(negedge clk);
        in_data = d; in_nit = nit; in_derr = derr; in_isk = isk;
        in_comma = cm; in_rdisp = rd; in_ccnt = cc;
        e.e = 1'b0;
        sw  = m_swap;
        e.v = m_lock;
        if (cm == 4'b1000) begin
            sw = 1'b0; e.v = 1'b1; m_lock = 1'b1;
        end else if (cm == 4'b0010) begin
            e.v = m_lock && m_swap; sw = 1'b1; m_lock = 1'b1;
        end else if (cm != 4'b0000) begin
            e.e = 1'b1;
        end
        m_swap = sw;
        e.d   = sw ? {m_pd, d[31:16]} : d;
        e.nit = spl4(sw, m_pn, nit);
        e.derr = spl4(sw, m_pe, derr);
        e.isk = spl4(sw, m_pk, isk);
        e.cm  = spl4(sw, m_pc, cm);
        e.rd  = spl4(sw, m_pr, rd);
        e.cc  = cc;
        e.req = req;
        m_pd = d[15:0]; m_pn = nit[1:0]; m_pe = derr[1:0];
        m_pk = isk[1:0]; m_pc = cm[1:0]; m_pr = rd[1:0];
        sb.push_back(e);
    endtask

    // Monitor: each result is due one rising edge after its input word.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (out_data !== e.d || out_nit !== e.nit || out_derr !== e.derr ||
                out_isk !== e.isk || out_comma !== e.cm || out_rdisp !== e.rd ||
                out_ccnt !== e.cc || out_valid !== e.v || align_err !== e.e) begin
                errors++;
                $display("FAIL %s: got d=%h n=%b de=%b k=%b c=%b r=%b cc=%0d v=%b e=%b exp d=%h n=%b de=%b k=%b c=%b r=%b cc=%0d v=%b e=%b",
                         e.req, out_data, out_nit, out_derr, out_isk, out_comma, out_rdisp,
                         out_ccnt, out_valid, align_err, e.d, e.nit, e.derr, e.isk, e.cm,
                         e.rd, e.cc, e.v, e.e);
            end
        end
    end

    task automatic check_reset_state(input string req);
        checks++;
        if (out_data !== '0 || out_valid !== 1'b0 || align_err !== 1'b0 || out_ccnt !== '0 ||
            out_isk !== '0 || out_comma !== '0) begin
            errors++;
            $display("FAIL %s: got d=%h v=%b e=%b cc=%0d exp all zero", req, out_data,
                     out_valid, align_err, out_ccnt);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        in_data = '0; in_nit = '0; in_derr = '0; in_isk = '0;
        in_comma = '0; in_rdisp = '0; in_ccnt = '0;
        @(negedge clk);
        check_reset_state("R9 reset");
        rst = 1'b0;
        m_swap = 1'b0; m_lock = 1'b0; m_pd = '0;
        m_pn = '0; m_pe = '0; m_pk = '0; m_pc = '0; m_pr = '0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("R9 initial");
        rst = 1'b0;
        // R8: nothing valid before a comma.
        drive(32'h1111_2222, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0101, 3'd1, "R8 pre-lock");
        // R2 pass mode, R1 one-cycle latency, R5 mode held.
        drive(32'hBC95_B5B5, 4'b0000, 4'b0000, 4'b1000, 4'b1000, 4'b1010, 3'd2, "R2 pass comma");
        drive(32'hFDB5_3737, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0110, 3'd3, "R5 pass hold");
        drive(32'h4567_4893, 4'b0000, 4'b0100, 4'b0001, 4'b0000, 4'b1001, 3'd4, "R4 pass status");
        // R3 switch into swap mode: first spliced word invalid (R8).
        drive(32'h0000_BC95, 4'b0000, 4'b0000, 4'b0010, 4'b0010, 4'b0011, 3'd5, "R8 swap entry");
        drive(32'hB5B5_FDB5, 4'b0001, 4'b1000, 4'b0000, 4'b0000, 4'b1100, 3'd6, "R3 splice BC95B5B5");
        drive(32'h3737_4567, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0101, 3'd7, "R5 swap hold");
        drive(32'h4893_0000, 4'b0000, 4'b0010, 4'b0100, 4'b0000, 4'b1110, 3'd0, "R4 swap status");
        // R8: a repeated mid-lane comma keeps the output valid.
        drive(32'hAAAA_BC95, 4'b0000, 4'b0000, 4'b0010, 4'b0010, 4'b0001, 3'd1, "R8 swap recomma");
        // R7: unsupported lanes raise the error and keep swap mode.
        drive(32'h1234_5678, 4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0000, 3'd2, "R7 lane2 comma");
        drive(32'h9ABC_DEF0, 4'b0000, 4'b0000, 4'b0001, 4'b0001, 4'b1111, 3'd3, "R7 lane0 comma");
        drive(32'hCAFE_F00D, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd4, "R7 mode kept");
        // R6: count is copied unspliced across a run of swap-mode words.
        for (int i = 0; i < 8; i++) begin
            drive(32'h1357_9BDF ^ (32'h0101_0101 * i), 4'(i), 4'(i * 3), 4'(i * 5),
                  4'b0000, 4'(i * 7), 3'(i), "R6 swap run");
        end
        // R2: back to pass mode, valid at once.
        drive(32'hBC95_0102, 4'b0000, 4'b0000, 4'b1000, 4'b1000, 4'b0110, 3'd5, "R2 back to pass");
        drive(32'h0304_0506, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b1001, 3'd6, "R1 pass latency");
        // R7 in pass mode.
        drive(32'h0708_090A, 4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0000, 3'd7, "R7 pass lane2");
        drive(32'h0B0C_0D0E, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd0, "R7 pass kept");
        @(negedge clk);
        @(negedge clk);
        // R9: mid-run reset, then swap comma before lock is invalid.
        apply_reset();
        drive(32'h5555_AAAA, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd1, "R9 after reset");
        drive(32'h0000_BC95, 4'b0000, 4'b0000, 4'b0010, 4'b0010, 4'b0000, 3'd2, "R8 first comma swap");
        drive(32'hB5B5_1234, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 3'd3, "R3 splice after lock");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule